// File: doc/BRIEF.md
# Jump Resolution and Program Counter Unit

This block owns the program counter of a small virtual machine with 64-bit registers and 64-bit instruction slots. Each cycle it may accept one decoded instruction: the opcode byte, the values already read for the destination and source registers, the 16-bit signed offset and the 32-bit immediate. Jump-class instructions are resolved against an unsigned, signed or bit-test condition. The counter then moves to the sequential slot or to the branch target. Instructions of any other class simply advance the counter by one slot.

Two special jump-class opcodes do not branch. One raises a single-cycle request to call the function named by the immediate, and execution continues at the next slot. The other stops the machine, leaving register 0 as the result. The machine then stays stopped with a frozen counter until reset. Jump-class opcodes that are not defined raise an illegal-instruction flag and leave the counter where it was. Instruction fetch, the call handler and the return-value path sit outside this block.

Top module: `vm_jump_unit`

## Requirements
- R1: While reset is asserted and after reset is released, `pc_o` equals the parameter `RESET_PC` (default 0), `call_id_o` is 0, and `taken_o`, `call_req_o`, `halted_o` and `illegal_o` are all 0.
- R2: An accepted instruction whose opcode bits [2:0] are not 5 advances the counter by exactly one slot, and it raises no taken, call or illegal flag.
- R3: For a conditional jump, opcode bit 3 selects the operand that is compared with the destination value. When the bit is 0, the operand is the immediate sign-extended to 64 bits. When the bit is 1, the operand is the source value.
- R4: Opcode 0x05 is an unconditional jump. It is always taken, whatever the register values are.
- R5: Opcode bits [7:4] select the unsigned conditions: 1 is equal, 2 is greater, 3 is greater-or-equal and 5 is not-equal.
- R6: Opcode bits [7:4] set to 6 select signed greater, and set to 7 select signed greater-or-equal. Both conditions compare the operands as two's-complement 64-bit values.
- R7: Opcode bits [7:4] set to 4 select the bit test. It is taken exactly when the destination value ANDed with the operand is nonzero.
- R8: A taken jump moves `pc_o` to PC + 1 + the sign-extended offset, modulo 2^PC_W. A jump that is not taken moves `pc_o` to PC + 1. In the cycle after the instruction edge, `taken_o` reports whether the jump was taken.
- R9: Opcode 0x85 pulses `call_req_o` for one cycle and loads `call_id_o` with the immediate. The counter goes to PC + 1, and `taken_o` stays 0. `call_id_o` keeps its value until the next call.
- R10: Opcode 0x95 sets `halted_o` and leaves the counter unchanged. From then on, `halted_o` stays 1 and every accepted instruction is ignored, until reset.
- R11: A jump-class opcode other than 0x05, 0x15, 0x1d, 0x25, 0x2d, 0x35, 0x3d, 0x45, 0x4d, 0x55, 0x5d, 0x65, 0x6d, 0x75, 0x7d, 0x85 or 0x95 pulses `illegal_o` for one cycle and leaves the counter unchanged.
- R12: While `instr_valid_i` is 0, the counter holds its value and no pulse flag is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid_i | input | 1 | An instruction is presented this cycle |
| opcode_i | input | 8 | Opcode byte |
| dst_val_i | input | 64 | Destination register value |
| src_val_i | input | 64 | Source register value |
| offset_i | input | 16 | Signed jump offset in slots |
| imm_i | input | 32 | Immediate field |
| pc_o | output | PC_W | Current program counter in slots |
| taken_o | output | 1 | The last instruction was a taken jump |
| call_req_o | output | 1 | One-cycle call request |
| call_id_o | output | 32 | Immediate of the most recent call |
| halted_o | output | 1 | The machine has stopped |
| illegal_o | output | 1 | The last instruction was an undefined jump-class opcode |

## Verification
The embedded properties check the invariants that hold on every cycle:
- a stopped machine keeps its counter frozen and stays stopped;
- an idle cycle changes nothing;
- an illegal opcode leaves the counter unchanged;
- at most one of the taken, call and illegal pulses is raised;
- a call never reports a taken jump.

The outcome of each condition code depends on the data: signed compared with unsigned ordering, sign extension of the immediate, the bit-test result and target arithmetic that wraps around. Only the bench's mix of random operands and directed boundary values can show these cases, because it compares every outcome with an independent reference model.

// File: rtl/vm_jump_pkg.sv
package vm_jump_pkg;
  localparam int XLEN  = 64;
  localparam int OFF_W = 16;
  localparam int IMM_W = 32;
  localparam int OP_W  = 8;
  localparam logic [2:0] JUMP_CLASS = 3'd5;
  localparam logic [OP_W-1:0] OP_CALL = 8'h85;
  localparam logic [OP_W-1:0] OP_STOP = 8'h95;

  typedef enum logic [2:0] {
    COND_ALWAYS = 3'd0,
    COND_EQ     = 3'd1,
    COND_UGT    = 3'd2,
    COND_UGE    = 3'd3,
    COND_TEST   = 3'd4,
    COND_NE     = 3'd5,
    COND_SGT    = 3'd6,
    COND_SGE    = 3'd7
  } cond_e;

  typedef struct packed {
    logic  jump_cls;
    logic  branch;
    logic  call;
    logic  stop;
    logic  bad;
    logic  use_src;
    cond_e cond;
  } jdec_t;

  function automatic logic [XLEN-1:0] widen_imm(input logic [IMM_W-1:0] imm);
    return XLEN'($signed(imm));
  endfunction

  function automatic logic cond_hit(input cond_e c,
                                    input logic [XLEN-1:0] a,
                                    input logic [XLEN-1:0] b);
    logic hit;
    unique case (c)
      COND_ALWAYS: hit = 1'b1;
      COND_EQ:     hit = (a == b);
      COND_UGT:    hit = (a > b);
      COND_UGE:    hit = (a >= b);
      COND_TEST:   hit = |(a & b);
      COND_NE:     hit = (a != b);
      COND_SGT:    hit = ($signed(a) > $signed(b));
      COND_SGE:    hit = ($signed(a) >= $signed(b));
      default:     hit = 1'b0;
    endcase
    return hit;
  endfunction
endpackage

// File: rtl/vm_jump_decode.sv
module vm_jump_decode
  import vm_jump_pkg::*;
(
  input  logic [OP_W-1:0] opcode_i,
  output jdec_t           dec_o
);
  logic       in_class;
  logic       high;
  logic [2:0] code;
  logic       sel;

  assign in_class = (opcode_i[2:0] == JUMP_CLASS);
  assign high     = opcode_i[7];
  assign code     = opcode_i[6:4];
  assign sel      = opcode_i[3];

  always_comb begin
    dec_o          = '0;
    dec_o.jump_cls = in_class;
    dec_o.use_src  = sel;
    dec_o.cond     = cond_e'(code);
    if (in_class) begin
      if (opcode_i == OP_CALL)      dec_o.call = 1'b1;
      else if (opcode_i == OP_STOP) dec_o.stop = 1'b1;
      else if (!high && !(code == 3'd0 && sel)) dec_o.branch = 1'b1;
      else dec_o.bad = 1'b1;
    end
  end
endmodule

// File: rtl/vm_jump_cond.sv
module vm_jump_cond
  import vm_jump_pkg::*;
(
  input  cond_e            cond_i,
  input  logic             use_src_i,
  input  logic [XLEN-1:0]  dst_i,
  input  logic [XLEN-1:0]  src_i,
  input  logic [IMM_W-1:0] imm_i,
  output logic             hit_o
);
  logic [XLEN-1:0] operand;

  assign operand = use_src_i ? src_i : widen_imm(imm_i);
  assign hit_o   = cond_hit(cond_i, dst_i, operand);
endmodule

// File: rtl/vm_jump_unit.sv
module vm_jump_unit
  import vm_jump_pkg::*;
#(
  parameter int              PC_W     = 32,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             instr_valid_i,
  input  logic [7:0]       opcode_i,
  input  logic [63:0]      dst_val_i,
  input  logic [63:0]      src_val_i,
  input  logic [15:0]      offset_i,
  input  logic [31:0]      imm_i,
  output logic [PC_W-1:0]  pc_o,
  output logic             taken_o,
  output logic             call_req_o,
  output logic [31:0]      call_id_o,
  output logic             halted_o,
  output logic             illegal_o
);
  jdec_t           dec;
  logic            hit;
  logic            accept;
  logic            take_now;
  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] pc_seq;
  logic [PC_W-1:0] pc_tgt;
  logic [PC_W-1:0] pc_d;
  logic            taken_q, call_q, stop_q, bad_q;
  logic [IMM_W-1:0] call_id_q;

  vm_jump_decode u_decode (
    .opcode_i (opcode_i),
    .dec_o    (dec)
  );

  vm_jump_cond u_cond (
    .cond_i    (dec.cond),
    .use_src_i (dec.use_src),
    .dst_i     (dst_val_i),
    .src_i     (src_val_i),
    .imm_i     (imm_i),
    .hit_o     (hit)
  );

  assign accept   = instr_valid_i && !stop_q;
  assign take_now = accept && dec.branch && hit;
  assign pc_seq   = pc_q + PC_W'(1);
  assign pc_tgt   = pc_seq + PC_W'($signed(offset_i));

  always_comb begin
    pc_d = pc_q;
    if (accept) begin
      if (!dec.jump_cls)           pc_d = pc_seq;
      else if (dec.branch)         pc_d = hit ? pc_tgt : pc_seq;
      else if (dec.call)           pc_d = pc_seq;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q      <= RESET_PC;
      taken_q   <= 1'b0;
      call_q    <= 1'b0;
      stop_q    <= 1'b0;
      bad_q     <= 1'b0;
      call_id_q <= '0;
    end else begin
      pc_q    <= pc_d;
      taken_q <= take_now;
      call_q  <= accept && dec.call;
      bad_q   <= accept && dec.bad;
      if (accept && dec.stop) stop_q <= 1'b1;
      if (accept && dec.call) call_id_q <= imm_i;
    end
  end

  assign pc_o       = pc_q;
  assign taken_o    = taken_q;
  assign call_req_o = call_q;
  assign call_id_o  = call_id_q;
  assign halted_o   = stop_q;
  assign illegal_o  = bad_q;

  // R10: a stopped machine keeps its counter and stays stopped
  a_r10_halt_freezes_pc: assert property (@(posedge clk) disable iff (!rst_n)
    stop_q |=> ($stable(pc_q) && stop_q));
  // R12: idle cycle changes nothing
  a_r12_idle_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid_i |=> ($stable(pc_q) && !taken_q && !call_q && !bad_q));
  // R11: undefined opcode keeps the counter
  a_r11_illegal_holds_pc: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && dec.bad) |=> (bad_q && $stable(pc_q)));
  // R9: call request never reports a taken jump
  a_r9_call_not_taken: assert property (@(posedge clk) disable iff (!rst_n)
    call_q |-> (!taken_q && !bad_q));
  // R8/R9/R11: pulse flags are mutually exclusive
  a_r8_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({taken_q, call_q, bad_q}) <= 1);
  // R4: unconditional jump is always taken
  a_r4_always_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && opcode_i == 8'h05) |=> taken_q);
endmodule

// File: tb/vm_jump_unit_tb.sv
module vm_jump_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            instr_valid_i = 1'b0;
  logic [7:0]      opcode_i = '0;
  logic [63:0]     dst_val_i = '0;
  logic [63:0]     src_val_i = '0;
  logic [15:0]     offset_i = '0;
  logic [31:0]     imm_i = '0;
  logic [PC_W-1:0] pc_o;
  logic            taken_o, call_req_o, halted_o, illegal_o;
  logic [31:0]     call_id_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [PC_W-1:0] m_pc;
  logic            m_taken, m_call, m_halt, m_bad;
  logic [31:0]     m_id;

  always #(CLK_PERIOD/2) clk = ~clk;

  vm_jump_unit #(.PC_W(PC_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .instr_valid_i(instr_valid_i),
    .opcode_i(opcode_i), .dst_val_i(dst_val_i), .src_val_i(src_val_i),
    .offset_i(offset_i), .imm_i(imm_i), .pc_o(pc_o), .taken_o(taken_o),
    .call_req_o(call_req_o), .call_id_o(call_id_o), .halted_o(halted_o),
    .illegal_o(illegal_o)
  );

  function automatic bit is_defined(input logic [7:0] op);
    case (op)
      8'h05, 8'h15, 8'h1d, 8'h25, 8'h2d, 8'h35, 8'h3d, 8'h45, 8'h4d,
      8'h55, 8'h5d, 8'h65, 8'h6d, 8'h75, 8'h7d, 8'h85, 8'h95: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit ref_taken(input logic [7:0] op, input logic [63:0] d,
                                   input logic [63:0] s, input logic [31:0] im);
    longint unsigned ud, uo;
    longint sd, so;
    ud = d;
    uo = op[3] ? s : {{32{im[31]}}, im};
    sd = $signed(ud);
    so = $signed(uo);
    case (op[7:4])
      4'h0: return 1'b1;
      4'h1: return ud == uo;
      4'h2: return ud > uo;
      4'h3: return ud >= uo;
      4'h4: return (ud & uo) != 0;
      4'h5: return ud != uo;
      4'h6: return sd > so;
      4'h7: return sd >= so;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check1(input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic compare_all(input string req);
    check1(req, "pc", 64'(pc_o), 64'(m_pc));
    check1(req, "taken", 64'(taken_o), 64'(m_taken));
    check1(req, "call_req", 64'(call_req_o), 64'(m_call));
    check1(req, "call_id", 64'(call_id_o), 64'(m_id));
    check1(req, "halted", 64'(halted_o), 64'(m_halt));
    check1(req, "illegal", 64'(illegal_o), 64'(m_bad));
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    instr_valid_i = 1'b0;
    repeat (2) @(negedge clk);
    m_pc = '0; m_taken = 0; m_call = 0; m_halt = 0; m_bad = 0; m_id = '0;
    compare_all("R1");
    rst_n = 1'b1;
    @(posedge clk); #1;
    compare_all("R1");
    @(negedge clk);
  endtask

  // called at a negedge; returns at the following negedge
  task automatic step(input string req, input logic v, input logic [7:0] op,
                      input logic [63:0] d, input logic [63:0] s,
                      input logic [15:0] off, input logic [31:0] im);
    instr_valid_i = v; opcode_i = op; dst_val_i = d; src_val_i = s;
    offset_i = off; imm_i = im;
    m_taken = 0; m_call = 0; m_bad = 0;
    if (v && !m_halt) begin
      if (op[2:0] != 3'd5) m_pc = m_pc + 1;
      else if (!is_defined(op)) m_bad = 1;
      else if (op == 8'h95) m_halt = 1;
      else if (op == 8'h85) begin m_call = 1; m_id = im; m_pc = m_pc + 1; end
      else if (ref_taken(op, d, s, im)) begin
        m_taken = 1;
        m_pc = m_pc + 1 + {{16{off[15]}}, off};
      end else m_pc = m_pc + 1;
    end
    @(posedge clk); #1;
    compare_all(req);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    @(negedge clk);
    do_reset();
    // directed corners
    step("R2", 1, 8'h07, 64'd1, 64'd2, 16'h0010, 32'd0);
    step("R4", 1, 8'h05, 64'd0, 64'd0, 16'h0020, 32'd0);
    step("R8", 1, 8'h05, 64'd9, 64'd9, 16'hffff, 32'd0);        // target = same slot
    step("R3", 1, 8'h15, 64'hffff_ffff_ffff_fff0, 64'd0, 16'd3, 32'hffff_fff0);
    step("R3", 1, 8'h1d, 64'd5, 64'd6, 16'd3, 32'd5);
    step("R5", 1, 8'h25, 64'hffff_ffff_0000_0000, 64'd0, 16'd4, 32'h7fff_ffff);
    step("R5", 1, 8'h3d, 64'd7, 64'd7, 16'hfff0, 32'd0);
    step("R5", 1, 8'h55, 64'd1, 64'd0, 16'd2, 32'd1);
    step("R6", 1, 8'h6d, 64'hffff_ffff_ffff_ffff, 64'd1, 16'd2, 32'd0);
    step("R6", 1, 8'h75, 64'd0, 64'd0, 16'd6, 32'hffff_ffff);
    step("R7", 1, 8'h4d, 64'hf0, 64'h0f, 16'd8, 32'd0);
    step("R7", 1, 8'h45, 64'h8000_0000_0000_0000, 64'd0, 16'd8, 32'h8000_0000);
    step("R9", 1, 8'h85, 64'd0, 64'd0, 16'd0, 32'hcafe_0001);
    step("R9", 1, 8'h07, 64'd0, 64'd0, 16'd0, 32'd0);
    step("R11", 1, 8'h0d, 64'd0, 64'd0, 16'd5, 32'd0);
    step("R11", 1, 8'h8d, 64'd0, 64'd0, 16'd5, 32'd0);
    step("R11", 1, 8'hf5, 64'd0, 64'd0, 16'd5, 32'd0);
    step("R12", 0, 8'h05, 64'd0, 64'd0, 16'd7, 32'd0);
    step("R10", 1, 8'h95, 64'd0, 64'd0, 16'd7, 32'd0);
    step("R10", 1, 8'h05, 64'd0, 64'd0, 16'd7, 32'd0);
    step("R10", 1, 8'h85, 64'd0, 64'd0, 16'd7, 32'h1234);
    do_reset();
    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [7:0]  op;
      logic [63:0] d, s;
      logic [31:0] im;
      int sel;
      sel = $urandom % 100;
      if (sel < 70) op = {1'b0, 3'($urandom), 1'($urandom), 3'd5};
      else if (sel < 78) op = 8'($urandom);
      else if (sel < 84) op = 8'h85;
      else if (sel < 86) op = 8'h95;
      else op = {4'($urandom), 1'($urandom), 3'd5};
      d  = {$urandom, $urandom};
      im = $urandom;
      case ($urandom % 4)
        0: s = d;
        1: begin s = {$urandom, $urandom}; d = {{32{im[31]}}, im}; end
        2: begin d = 64'($urandom % 8); s = 64'($urandom % 8); im = $urandom % 8; end
        default: s = {$urandom, $urandom};
      endcase
      step("R8", ($urandom % 8) != 0, op, d, s, 16'($urandom), im);
      if (m_halt && ($urandom % 4 == 0)) do_reset();
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule